// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns a six-byte window of instruction bytes, fetched at the current program counter of a small 32-bit processor, into decoded fields. From the first byte it takes the operation class and its variant. From the first byte alone it also works out how long the instruction is: 1, 2, 5 or 6 bytes. It then picks out the two register specifiers and a 32-bit constant, reports the address of the next sequential instruction, and flags encodings that are not legal.

A window enters on a valid/ready handshake together with its PC. The decoded result sits in one output register and leaves on a second valid/ready handshake. The upstream side may present a window only while the block can take it. The block takes a new window whenever its output register is empty, or is being emptied in the same cycle. So a steady stream flows at one instruction per clock. When the consumer stalls, the held result stays frozen and the input side stalls behind it. Byte k of the window sits on bits [8k+7:8k] of the window input.

Top module: `instr_decoder`

## Requirements
- R1: A window is taken on a rising edge where `in_valid` and `in_ready` are both high, and its result is shown with `out_valid` high from the next cycle. `in_ready` is high exactly when the output register is empty or `out_ready` is high.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` and every result output keep their values on the next cycle.
- R3: `out_opcode` is bits [7:4] of byte 0 and `out_variant` is bits [3:0] of byte 0.
- R4: The length depends only on the opcode. Opcodes 0, 1 and 9 give 1 byte. Opcodes 2, 6, 0xA and 0xB give 2 bytes. Opcodes 7 and 8 give 5 bytes. Opcodes 3, 4 and 5 give 6 bytes. Any opcode above 0xB gives 1 byte.
- R5: For opcodes 2, 3, 4, 5, 6, 0xA and 0xB, `out_reg_a` is bits [7:4] of byte 1 and `out_reg_b` is bits [3:0] of byte 1. For every other opcode both read 0xF.
- R6: For opcodes 7 and 8 the constant is bytes 1 to 4 taken little-endian, with byte 1 as the least significant. For opcodes 3, 4 and 5 it is bytes 2 to 5 taken the same way. For every other opcode it is zero. For example, 30 f2 cd ab 00 00 gives constant 0x0000abcd and `out_reg_b` = 2.
- R7: `out_illegal` is high when the opcode is above 0xB. It is also high when the opcode is 6 and the variant is above 3, when the opcode is 7 and the variant is above 6, or when any other opcode has a nonzero variant.
- R8: `out_next_pc` equals the accepted PC plus the length, modulo 2^32.
- R9: An all-zero window decodes as opcode 0, legal, length 1.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and PC are presented |
| in_ready | output | 1 | Block can take a window this cycle |
| in_pc | input | 32 | Address of byte 0 |
| in_window | input | 48 | Six instruction bytes, byte 0 in bits [7:0] |
| out_valid | output | 1 | Decoded result is held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_opcode | output | 4 | Operation class |
| out_variant | output | 4 | Operation variant |
| out_reg_a | output | 4 | First register specifier, 0xF if absent |
| out_reg_b | output | 4 | Second register specifier, 0xF if absent |
| out_const | output | 32 | Assembled constant, zero if absent |
| out_len | output | 3 | Instruction length in bytes |
| out_next_pc | output | 32 | PC plus length |
| out_illegal | output | 1 | Encoding is not legal |

## Verification
Two things can land on the same clock edge: the output register hands a result to the consumer, and it loads the next window from upstream. The bench drives windows back to back while the consumer's ready line is switched between always-on, pseudo-random and mostly-off patterns. In the mixed patterns, hand-off and refill often coincide, and long stalls pile up pressure on the input side. Every accepted window goes into a scoreboard queue. Each result must come out in order, with no loss and no duplicate, and must match fields computed from the requirements. Results held under stall must not change.

// File: rtl/vld_pkg.sv
package vld_pkg;

  localparam int WORD_W    = 32;
  localparam int WIN_BYTES = 6;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int LEN_W     = 3;
  localparam int NIB_W     = 4;
  localparam logic [NIB_W-1:0] NO_REG = 4'hF;

  typedef enum logic [NIB_W-1:0] {
    OP_STOP  = 4'h0,
    OP_IDLE  = 4'h1,
    OP_MOVRR = 4'h2,
    OP_MOVIR = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_BR    = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  localparam logic [NIB_W-1:0] ALU_VAR_MAX = 4'd3;
  localparam logic [NIB_W-1:0] BR_VAR_MAX  = 4'd6;

  // where the constant starts inside the window
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_AT1  = 2'd1,
    K_AT2  = 2'd2
  } const_pos_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             has_regs;
    const_pos_e       kpos;
    logic             known;
  } format_t;

  typedef struct packed {
    logic [NIB_W-1:0]  opcode;
    logic [NIB_W-1:0]  variant;
    logic [NIB_W-1:0]  reg_a;
    logic [NIB_W-1:0]  reg_b;
    logic [WORD_W-1:0] kval;
    logic [LEN_W-1:0]  len;
    logic [WORD_W-1:0] next_pc;
    logic              illegal;
  } decoded_t;

endpackage

// File: rtl/vld_format.sv
module vld_format
  import vld_pkg::*;
(
  input  logic [NIB_W-1:0] opcode,
  output format_t          fmt
);

  always_comb begin
    fmt = '{len: 3'd1, has_regs: 1'b0, kpos: K_NONE, known: 1'b1};
    case (opcode)
      OP_STOP, OP_IDLE, OP_RET: begin
        fmt.len = 3'd1;
      end
      OP_MOVRR, OP_ALU, OP_PUSH, OP_POP: begin
        fmt.len      = 3'd2;
        fmt.has_regs = 1'b1;
      end
      OP_BR, OP_CALL: begin
        fmt.len  = 3'd5;
        fmt.kpos = K_AT1;
      end
      OP_MOVIR, OP_STORE, OP_LOAD: begin
        fmt.len      = 3'd6;
        fmt.has_regs = 1'b1;
        fmt.kpos     = K_AT2;
      end
      default: begin
        fmt.known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vld_fields.sv
module vld_fields
  import vld_pkg::*;
(
  input  logic [WIN_W-1:0]  window,
  input  format_t           fmt,
  output logic [NIB_W-1:0]  reg_a,
  output logic [NIB_W-1:0]  reg_b,
  output logic [WORD_W-1:0] kval,
  output logic              illegal
);

  localparam int KBYTES = WORD_W / 8;

  logic [7:0] bytes [WIN_BYTES];

  genvar gi;
  generate
    for (gi = 0; gi < WIN_BYTES; gi++) begin : g_split
      assign bytes[gi] = window[8*gi +: 8];
    end
  endgenerate

  logic [NIB_W-1:0] opc, var_n;
  assign opc   = bytes[0][7:4];
  assign var_n = bytes[0][3:0];

  assign reg_a = fmt.has_regs ? bytes[1][7:4] : NO_REG;
  assign reg_b = fmt.has_regs ? bytes[1][3:0] : NO_REG;

  // little-endian assembly: lowest window byte lands in the low bits
  generate
    for (gi = 0; gi < KBYTES; gi++) begin : g_kbyte
      always_comb begin
        case (fmt.kpos)
          K_AT1:   kval[8*gi +: 8] = bytes[gi+1];
          K_AT2:   kval[8*gi +: 8] = bytes[gi+2];
          default: kval[8*gi +: 8] = 8'h00;
        endcase
      end
    end
  endgenerate

  always_comb begin
    if (!fmt.known) begin
      illegal = 1'b1;
    end else begin
      case (opc)
        OP_ALU:  illegal = (var_n > ALU_VAR_MAX);
        OP_BR:   illegal = (var_n > BR_VAR_MAX);
        default: illegal = (var_n != 4'h0);
      endcase
    end
  end

endmodule

// File: rtl/vld_outreg.sv
module vld_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) begin
      data_q <= up_data;
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import vld_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_pc,
  input  logic [WIN_W-1:0]  in_window,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NIB_W-1:0]  out_opcode,
  output logic [NIB_W-1:0]  out_variant,
  output logic [NIB_W-1:0]  out_reg_a,
  output logic [NIB_W-1:0]  out_reg_b,
  output logic [WORD_W-1:0] out_const,
  output logic [LEN_W-1:0]  out_len,
  output logic [WORD_W-1:0] out_next_pc,
  output logic              out_illegal
);

  localparam int DEC_W = $bits(decoded_t);

  format_t  fmt;
  decoded_t dec_d, dec_q;

  vld_format u_format (
    .opcode (in_window[7:4]),
    .fmt    (fmt)
  );

  logic [NIB_W-1:0]  f_ra, f_rb;
  logic [WORD_W-1:0] f_k;
  logic              f_bad;

  vld_fields u_fields (
    .window  (in_window),
    .fmt     (fmt),
    .reg_a   (f_ra),
    .reg_b   (f_rb),
    .kval    (f_k),
    .illegal (f_bad)
  );

  always_comb begin
    dec_d.opcode  = in_window[7:4];
    dec_d.variant = in_window[3:0];
    dec_d.reg_a   = f_ra;
    dec_d.reg_b   = f_rb;
    dec_d.kval    = f_k;
    dec_d.len     = fmt.len;
    dec_d.next_pc = in_pc + {{(WORD_W-LEN_W){1'b0}}, fmt.len};
    dec_d.illegal = f_bad;
  end

  vld_outreg #(.W(DEC_W)) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (dec_d),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (dec_q)
  );

  assign out_opcode  = dec_q.opcode;
  assign out_variant = dec_q.variant;
  assign out_reg_a   = dec_q.reg_a;
  assign out_reg_b   = dec_q.reg_b;
  assign out_const   = dec_q.kval;
  assign out_len     = dec_q.len;
  assign out_next_pc = dec_q.next_pc;
  assign out_illegal = dec_q.illegal;

endmodule

// File: rtl/vld_checker.sv
module vld_checker
  import vld_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NIB_W-1:0]  out_opcode,
  input logic [NIB_W-1:0]  out_variant,
  input logic [NIB_W-1:0]  out_reg_a,
  input logic [NIB_W-1:0]  out_reg_b,
  input logic [WORD_W-1:0] out_const,
  input logic [LEN_W-1:0]  out_len,
  input logic [WORD_W-1:0] out_next_pc,
  input logic              out_illegal
);

  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_opcode, out_variant,
      out_reg_a, out_reg_b, out_const, out_len, out_next_pc, out_illegal}))); // R2

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == 3'd1 || out_len == 3'd2 || out_len == 3'd5 || out_len == 3'd6)); // R4

  AST_ONE_BYTE_NO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len == 3'd1) |-> (out_reg_a == NO_REG && out_reg_b == NO_REG)); // R5

  AST_SHORT_NO_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len <= 3'd2) |-> (out_const == '0)); // R6

  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_opcode > 4'hB) |-> (out_illegal && out_len == 3'd1)); // R7

endmodule

bind instr_decoder vld_checker u_vld_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_opcode  (out_opcode),
  .out_variant (out_variant),
  .out_reg_a   (out_reg_a),
  .out_reg_b   (out_reg_b),
  .out_const   (out_const),
  .out_len     (out_len),
  .out_next_pc (out_next_pc),
  .out_illegal (out_illegal)
);

// File: tb/instr_decoder_test.sv
module instr_decoder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [47:0] in_window = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_opcode, out_variant, out_reg_a, out_reg_b;
  logic [31:0] out_const, out_next_pc;
  logic [2:0]  out_len;
  logic        out_illegal;

  instr_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_window(in_window), .out_valid(out_valid),
    .out_ready(out_ready), .out_opcode(out_opcode), .out_variant(out_variant),
    .out_reg_a(out_reg_a), .out_reg_b(out_reg_b), .out_const(out_const),
    .out_len(out_len), .out_next_pc(out_next_pc), .out_illegal(out_illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0]  opc, var_n, ra, rb;
    logic [31:0] k, npc;
    logic [2:0]  len;
    logic        bad;
    bit          zero_win;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  int   rdy_mode = 0;
  bit   finished = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [47:0] w, input logic [31:0] pc);
    exp_t e;
    logic [3:0] o, v;
    o = w[7:4];
    v = w[3:0];
    e.opc = o; e.var_n = v; e.zero_win = (w == '0);
    case (o)
      4'h0, 4'h1, 4'h9:       e.len = 3'd1;
      4'h2, 4'h6, 4'hA, 4'hB: e.len = 3'd2;
      4'h7, 4'h8:             e.len = 3'd5;
      4'h3, 4'h4, 4'h5:       e.len = 3'd6;
      default:                e.len = 3'd1;
    endcase
    if (o inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB}) begin
      e.ra = w[15:12]; e.rb = w[11:8];
    end else begin
      e.ra = 4'hF; e.rb = 4'hF;
    end
    if (o == 4'h7 || o == 4'h8)                  e.k = w[39:8];
    else if (o inside {4'h3, 4'h4, 4'h5})        e.k = w[47:16];
    else                                         e.k = 32'h0;
    if (o > 4'hB)       e.bad = 1'b1;
    else if (o == 4'h6) e.bad = (v > 4'd3);
    else if (o == 4'h7) e.bad = (v > 4'd6);
    else                e.bad = (v != 4'h0);
    e.npc = pc + 32'(e.len);
    return e;
  endfunction

  // driver: present at negedge, accept on the edge where in_ready was high
  task automatic send(input logic [47:0] w, input logic [31:0] pc);
    bit taken = 0;
    @(negedge clk);
    in_valid  = 1'b1;
    in_window = w;
    in_pc     = pc;
    while (!taken) begin
      #2;
      if (out_ready)
        check(in_ready == 1'b1, "R1", "in_ready with out_ready high", 32'(in_ready), 32'h1);
      if (in_ready) begin
        taken = 1;
        sb.push_back(model(w, pc));
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // monitor: choose out_ready at negedge, compare the item that will leave
  initial begin : monitor
    bit stalled = 0;
    logic [31:0] snap_k, snap_npc;
    logic [15:0] snap_f;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && stalled) begin
        check(out_valid && out_const == snap_k && out_next_pc == snap_npc &&
              {out_opcode, out_variant, out_reg_a, out_reg_b} == snap_f,
              "R2", "held result changed", out_next_pc, snap_npc);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = lfsr[3];
        default: out_ready = (lfsr[4:2] == 3'b000);
      endcase
      #1;
      stalled = rst_n && out_valid && !out_ready;
      snap_k = out_const; snap_npc = out_next_pc;
      snap_f = {out_opcode, out_variant, out_reg_a, out_reg_b};
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "result with empty scoreboard", 32'h1, 32'h0);
        end else begin
          e = sb.pop_front();
          check(out_opcode == e.opc,    "R3", "opcode",   32'(out_opcode),  32'(e.opc));
          check(out_variant == e.var_n, "R3", "variant",  32'(out_variant), 32'(e.var_n));
          check(out_len == e.len,       "R4", "length",   32'(out_len),     32'(e.len));
          check(out_reg_a == e.ra,      "R5", "reg_a",    32'(out_reg_a),   32'(e.ra));
          check(out_reg_b == e.rb,      "R5", "reg_b",    32'(out_reg_b),   32'(e.rb));
          check(out_const == e.k,       "R6", "constant", out_const,        e.k);
          check(out_illegal == e.bad,   "R7", "illegal",  32'(out_illegal), 32'(e.bad));
          check(out_next_pc == e.npc,   "R8", "next pc",  out_next_pc,      e.npc);
          if (e.zero_win)
            check(out_opcode == 4'h0 && !out_illegal && out_len == 3'd1,
                  "R9", "zero window", {out_opcode, out_illegal, out_len}, 32'h1);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic directed(input logic [31:0] base);
    send(48'h0000_abcd_f230, base);           // move immediate, R6 example
    send(48'h0,              base + 6);       // all zero, R9
    send(48'h10,             base + 7);
    send(48'h90,             base + 8);
    send(48'h4320,           base + 9);
    send(48'h0660,           base + 11);
    send(48'h5463,           base + 13);
    send(48'h5464,           base + 15);      // variant 4 on alu: illegal
    send(48'h00_1122_3344_70, base + 17);
    send(48'h00_8000_0010_76, base + 22);
    send(48'h00_8000_0010_77, base + 27);     // variant 7 on branch: illegal
    send(48'h00_dead_beef_80, base + 32);
    send(48'h4fa0,           base + 37);
    send(48'h3fb0,           base + 39);
    send(48'h0000_041c_6440, base + 41);
    send(48'hffff_fff4_1550, base + 47);
    send(48'hffff_ffff_ffc0, base + 53);      // opcode above 0xB
    send(48'h11f0,           base + 54);
    send(48'h11,             base + 55);      // nonzero variant on idle
    send(48'h1234_5678_9a31, base + 56);      // nonzero variant on 6-byte
  endtask

  initial begin : main
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(out_valid == 1'b0, "R10", "out_valid in reset", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1,  "R10", "in_ready in reset",  32'(in_ready),  32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    rdy_mode = 0;
    directed(32'h0000_1000);
    send(48'h0000_0000_3020, 32'hFFFF_FFFE);  // next pc wraps, R8
    send(48'h00_0000_0000_80, 32'hFFFF_FFFD);
    rdy_mode = 1;
    directed(32'h0040_0000);
    for (int i = 0; i < 150; i++) begin
      logic [47:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = {lfsr[15:0], lfsr} ^ {lfsr, lfsr[31:16]};
      send(w, lfsr ^ 32'hA5A5_0000);
    end
    rdy_mode = 2;
    directed(32'h7FFF_FFF0);
    rdy_mode = 1;
    repeat (200) begin
      if (sb.size() == 0) break;
      @(negedge clk);
    end
    rdy_mode = 0;
    repeat (200) begin
      if (sb.size() == 0) break;
      @(negedge clk);
    end
    check(sb.size() == 0, "R1", "results left undelivered", sb.size(), 32'h0);
    finish_run();
  end

endmodule